// File: doc/BRIEF.md
# Frame noise statistics classifier

This block watches the residual stream of a video noise filter (each noisy input pixel minus its filtered value, already aligned to the pixel's coordinates) and decides, once per frame, which kind of noise the frame carries. It uses only a centred square window of the frame, and within it only every second column and every second row. For those residuals it keeps running sums of the first to fourth powers. At the frame-end strobe it turns those sums into exact, scaled central moments and sets a class: Gaussian, contaminated Gaussian or impulsive.

The class is registered and stays fixed for the whole following frame, so a coefficient store can use it directly to pick the filter set for that frame. In detail mode the fourth central moment is compared against two programmable multiples of three times the squared variance. In basic mode the third- and fourth-power accumulators are held idle. Only the variance is then compared against a limit, which separates short-tailed noise from long-tailed noise.

Top module: `nsc_classifier`

## Requirements
- R1: During and after reset, `noise_class` is Gaussian. The class codes are 2'b00 Gaussian, 2'b01 contaminated Gaussian and 2'b10 impulsive.
- R2: A residual contributes only when `pix_valid` is high and `frame_end` is low, and only at x = X0 + SUB·i and y = Y0 + SUB·j with 0 ≤ SUB·i, SUB·j < WIN. Here X0 = (FRAME_W−WIN)/2 and Y0 = (FRAME_H−WIN)/2. All other residuals have no effect on the class.
- R3: `noise_class` changes only on the third rising edge after the edge that samples `frame_end` high, and holds its value at all other times.
- R4: In detail mode, let k_lo = `near_k`/16 and k_hi = `far_k`/16. The class is Gaussian when µ4 ≤ k_lo·3σ⁴, impulsive when µ4 > k_hi·3σ⁴, and contaminated Gaussian otherwise. The comparison is exact and uses no rounding.
- R5: A frame whose sampled residuals are all equal (σ² = 0) is classed Gaussian in either mode and for any threshold values.
- R6: In basic mode the class is impulsive when σ² > `var_limit` and Gaussian otherwise. Basic mode never yields contaminated Gaussian, however heavy the tails of the sample set.
- R7: The mode and all three thresholds are taken from the cycle in which `frame_end` is high. Changes after that cycle do not affect the class decided from that frame.
- R8: Each frame's statistics start from zero. A frame's class depends only on the residuals sampled since the previous `frame_end`.
- R9: `noise_class` never carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Residual and position are valid this cycle |
| pix_x | input | XBITS | Column of the current pixel |
| pix_y | input | YBITS | Row of the current pixel |
| resid | input | RW | Signed residual, noisy minus filtered |
| frame_end | input | 1 | One-cycle strobe closing the frame |
| detail_en | input | 1 | 1: three-way decision on the fourth moment; 0: variance-only decision |
| near_k | input | 8 | Gaussian limit factor, unsigned Q4.4 |
| far_k | input | 8 | Impulsive limit factor, unsigned Q4.4 |
| var_limit | input | 2·RW | Variance limit used in basic mode |
| noise_class | output | 2 | Noise class decided from the last completed frame |

## Verification
On every cycle the assertions check three things: that the class only moves exactly three edges after a frame-end strobe, that it never takes the unused code, and that a frame closed in basic mode never produces the contaminated class. Whether a particular sample set lands in the right class can only be shown by the bench's scenarios. The same holds for the exact boundaries at the two moment thresholds and the variance limit, for the rejection of residuals outside the subsampled window, and for threshold changes made after the strobe being ignored. The bench works those out from its own integer moment sums.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  typedef enum logic [1:0] {
    NC_GAUSS   = 2'b00,
    NC_CONTAM  = 2'b01,
    NC_IMPULSE = 2'b10
  } noise_class_e;
endpackage

// File: rtl/nsc_window.sv
// Picks the subsampled centre-window residuals and registers them with the
// frame strobe so that later stages see one aligned stream.
module nsc_window #(
  parameter int FRAME_W = 720,
  parameter int FRAME_H = 576,
  parameter int WIN     = 64,
  parameter int SUB     = 2,
  parameter int RW      = 9,
  parameter int XBITS   = 10,
  parameter int YBITS   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic [XBITS-1:0]     pix_x,
  input  logic [YBITS-1:0]     pix_y,
  input  logic signed [RW-1:0] resid,
  input  logic                 frame_end,
  input  logic                 detail_en,
  output logic                 s_take,
  output logic signed [RW-1:0] s_res,
  output logic                 s_fin,
  output logic                 s_hi
);
  localparam int X0 = (FRAME_W - WIN) / 2;
  localparam int Y0 = (FRAME_H - WIN) / 2;

  logic in_x, in_y;
  always_comb begin
    in_x = (int'(pix_x) >= X0) && (int'(pix_x) < X0 + WIN) &&
           (((int'(pix_x) - X0) % SUB) == 0);
    in_y = (int'(pix_y) >= Y0) && (int'(pix_y) < Y0 + WIN) &&
           (((int'(pix_y) - Y0) % SUB) == 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_take <= 1'b0;
      s_res  <= '0;
      s_fin  <= 1'b0;
      s_hi   <= 1'b0;
    end else begin
      // a pixel arriving with the strobe belongs to no frame
      s_take <= pix_valid && in_x && in_y && !frame_end;
      s_res  <= resid;
      s_fin  <= frame_end;
      s_hi   <= detail_en;
    end
  end
endmodule

// File: rtl/nsc_accum.sv
// Power-sum accumulators, orders 1..4; orders 3 and 4 idle in basic mode.
module nsc_accum #(
  parameter int RW = 9,
  parameter int LN = 10,
  parameter int MW = 4 * RW + LN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic signed [RW-1:0] res,
  input  logic                 fin,
  input  logic                 hi_en,
  output logic signed [MW-1:0] s1,
  output logic signed [MW-1:0] s2,
  output logic signed [MW-1:0] s3,
  output logic signed [MW-1:0] s4,
  output logic                 snap_vld
);
  logic signed [MW-1:0] pw   [1:4];
  logic signed [MW-1:0] snap [1:4];

  assign pw[1] = MW'(res);

  for (genvar k = 2; k <= 4; k++) begin : g_pow
    assign pw[k] = pw[k-1] * pw[1];
  end

  for (genvar k = 1; k <= 4; k++) begin : g_ord
    localparam bit GATED = (k > 2);
    logic signed [MW-1:0] acc_r, snap_r;
    logic en;
    assign en = take && (!GATED || hi_en);
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_r  <= '0;
        snap_r <= '0;
      end else if (fin) begin
        snap_r <= acc_r;
        acc_r  <= '0;
      end else if (en) begin
        acc_r  <= acc_r + pw[k];
      end
    end
    assign snap[k] = snap_r;
  end

  assign s1 = snap[1];
  assign s2 = snap[2];
  assign s3 = snap[3];
  assign s4 = snap[4];

  always_ff @(posedge clk) begin
    if (rst) snap_vld <= 1'b0;
    else     snap_vld <= fin;
  end
endmodule

// File: rtl/nsc_decide.sv
// Two registered steps: scaled central moments, then threshold compare.
module nsc_decide
  import nsc_pkg::*;
#(
  parameter int RW = 9,
  parameter int LN = 10,
  parameter int MW = 4 * RW + LN,
  parameter int XW = 4 * RW + 4 * LN + 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld,
  input  logic signed [MW-1:0]   s1,
  input  logic signed [MW-1:0]   s2,
  input  logic signed [MW-1:0]   s3,
  input  logic signed [MW-1:0]   s4,
  input  logic                   detail,
  input  logic [7:0]             near_k,
  input  logic [7:0]             far_k,
  input  logic [2*RW-1:0]        var_limit,
  output logic [1:0]             noise_class
);
  logic signed [XW-1:0] e1, e2, e3, e4, p11, p13, p112, p1111;
  logic signed [XW-1:0] c2_n, c4_n, c2_r, c4_r;
  logic                 va;

  // c2 = N^2 * var, c4 = N^4 * mu4, both exact integers
  always_comb begin
    e1    = XW'(s1);
    e2    = XW'(s2);
    e3    = XW'(s3);
    e4    = XW'(s4);
    p11   = e1 * e1;
    p13   = e1 * e3;
    p112  = p11 * e2;
    p1111 = p11 * p11;
    c2_n  = (e2 <<< LN) - p11;
    c4_n  = (e4 <<< (3 * LN))
          - ((p13 <<< (2 * LN)) <<< 2)
          + (((p112 <<< LN) <<< 2) + ((p112 <<< LN) <<< 1))
          - ((p1111 <<< 1) + p1111);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_r <= '0;
      c4_r <= '0;
      va   <= 1'b0;
    end else begin
      va <= vld;
      if (vld) begin
        c2_r <= c2_n;
        c4_r <= c4_n;
      end
    end
  end

  logic signed [XW-1:0] sq, sq3, lhs, r_near, r_far, vlim;
  noise_class_e         cls_n, cls_q;

  always_comb begin
    sq     = c2_r * c2_r;
    sq3    = (sq <<< 1) + sq;
    lhs    = c4_r <<< 4;
    r_near = sq3 * $signed(XW'(near_k));
    r_far  = sq3 * $signed(XW'(far_k));
    vlim   = $signed(XW'(var_limit)) <<< (2 * LN);
    if (!detail)             cls_n = (c2_r > vlim) ? NC_IMPULSE : NC_GAUSS;
    else if (lhs <= r_near)  cls_n = NC_GAUSS;
    else if (lhs > r_far)    cls_n = NC_IMPULSE;
    else                     cls_n = NC_CONTAM;
  end

  always_ff @(posedge clk) begin
    if (rst)     cls_q <= NC_GAUSS;
    else if (va) cls_q <= cls_n;
  end

  assign noise_class = cls_q;
endmodule

// File: rtl/nsc_classifier.sv
module nsc_classifier #(
  parameter int FRAME_W = 720,
  parameter int FRAME_H = 576,
  parameter int WIN     = 64,
  parameter int SUB     = 2,
  parameter int RW      = 9,
  parameter int XBITS   = $clog2(FRAME_W),
  parameter int YBITS   = $clog2(FRAME_H)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic [XBITS-1:0]     pix_x,
  input  logic [YBITS-1:0]     pix_y,
  input  logic signed [RW-1:0] resid,
  input  logic                 frame_end,
  input  logic                 detail_en,
  input  logic [7:0]           near_k,
  input  logic [7:0]           far_k,
  input  logic [2*RW-1:0]      var_limit,
  output logic [1:0]           noise_class
);
  localparam int SIDE = WIN / SUB;
  localparam int LN   = 2 * $clog2(SIDE);
  localparam int MW   = 4 * RW + LN;
  localparam int XW   = 4 * RW + 4 * LN + 20;

  logic                 w_take, w_fin, w_hi, a_vld;
  logic signed [RW-1:0] w_res;
  logic signed [MW-1:0] a_s1, a_s2, a_s3, a_s4;

  // configuration frozen at the strobe
  logic            cfg_detail;
  logic [7:0]      cfg_near, cfg_far;
  logic [2*RW-1:0] cfg_vlim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_detail <= 1'b0;
      cfg_near   <= '0;
      cfg_far    <= '0;
      cfg_vlim   <= '0;
    end else if (frame_end) begin
      cfg_detail <= detail_en;
      cfg_near   <= near_k;
      cfg_far    <= far_k;
      cfg_vlim   <= var_limit;
    end
  end

  nsc_window #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN(WIN), .SUB(SUB),
    .RW(RW), .XBITS(XBITS), .YBITS(YBITS)
  ) u_win (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .resid(resid), .frame_end(frame_end),
    .detail_en(detail_en), .s_take(w_take), .s_res(w_res),
    .s_fin(w_fin), .s_hi(w_hi)
  );

  nsc_accum #(.RW(RW), .LN(LN), .MW(MW)) u_acc (
    .clk(clk), .rst(rst), .take(w_take), .res(w_res), .fin(w_fin),
    .hi_en(w_hi), .s1(a_s1), .s2(a_s2), .s3(a_s3), .s4(a_s4),
    .snap_vld(a_vld)
  );

  nsc_decide #(.RW(RW), .LN(LN), .MW(MW), .XW(XW)) u_dec (
    .clk(clk), .rst(rst), .vld(a_vld), .s1(a_s1), .s2(a_s2),
    .s3(a_s3), .s4(a_s4), .detail(cfg_detail), .near_k(cfg_near),
    .far_k(cfg_far), .var_limit(cfg_vlim), .noise_class(noise_class)
  );
endmodule

// File: rtl/nsc_classifier_chk.sv
module nsc_classifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_end,
  input logic       detail_en,
  input logic [1:0] noise_class
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1
  reset_gauss_chk: assert property (@(posedge clk)
    rst |=> noise_class == 2'b00);

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    noise_class != 2'b11);

  // R3
  update_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && noise_class != $past(noise_class))
      |-> $past(frame_end, 4));

  // R6
  basic_two_way_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(frame_end, 4) && !$past(detail_en, 4))
      |-> noise_class != 2'b01);
endmodule

bind nsc_classifier nsc_classifier_chk u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end),
  .detail_en(detail_en), .noise_class(noise_class)
);

// File: tb/nsc_classifier_bench.sv
`timescale 1ns/1ps
module nsc_classifier_bench;
  localparam int FW = 12, FH = 10, WIN = 8, SUB = 2, RW = 9, NS = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic pix_valid = 1'b0, frame_end = 1'b0, detail_en = 1'b0;
  logic [3:0] pix_x = '0, pix_y = '0;
  logic signed [RW-1:0] resid = '0;
  logic [7:0] near_k = 8'd24, far_k = 8'd64;
  logic [2*RW-1:0] var_limit = 18'd36;
  logic [1:0] noise_class;

  always #10 clk = ~clk;

  nsc_classifier #(.FRAME_W(FW), .FRAME_H(FH), .WIN(WIN), .SUB(SUB),
                   .RW(RW), .XBITS(4), .YBITS(4)) u_nsc_classifier (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .resid(resid), .frame_end(frame_end),
    .detail_en(detail_en), .near_k(near_k), .far_k(far_k),
    .var_limit(var_limit), .noise_class(noise_class)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;
  int smp [NS];
  int prev_cls = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // window origin (2,1), stride 2, 4x4 samples
  function automatic int samp_idx(input int x, input int y);
    if (x < 2 || x > 8 || y < 1 || y > 7) return -1;
    if ((x % 2) != 0 || (y % 2) != 1) return -1;
    return ((y - 1) / 2) * 4 + (x - 2) / 2;
  endfunction

  // exact moments via d = N*r - sum(r)
  function automatic int expect_cls(input bit det, input int nk, input int fk,
                                    input int vl);
    longint s1 = 0, a2 = 0, a4 = 0, d, lhs, sq3;
    for (int i = 0; i < NS; i++) s1 += smp[i];
    for (int i = 0; i < NS; i++) begin
      d = longint'(NS) * smp[i] - s1;
      a2 += d * d;
      a4 += d * d * d * d;
    end
    if (!det) return (a2 > longint'(vl) * NS * NS * NS) ? 2 : 0;
    lhs = a4 * NS * 16;
    sq3 = 3 * a2 * a2;
    if (lhs <= sq3 * nk) return 0;
    if (lhs > sq3 * fk) return 2;
    return 1;
  endfunction

  task automatic run_frame(input string req, input bit det, input int nk,
                           input int fk, input int vl, input bit swap);
    int exp_c;
    exp_c = expect_cls(det, nk, fk, vl);
    @(negedge clk);
    detail_en = det; near_k = 8'(nk); far_k = 8'(fk); var_limit = 18'(vl);
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) begin
        int id;
        id = samp_idx(x, y);
        pix_valid = 1'b1; pix_x = 4'(x); pix_y = 4'(y);
        resid = (id >= 0) ? RW'(smp[id]) : RW'(((x * 7 + y * 13) % 201) - 100);
        if (y == 4 && x == 0) chk("R3 class held mid-frame", noise_class, prev_cls);
        @(negedge clk);
      end
      pix_valid = 1'b0; resid = -9'sd77;   // junk while invalid (R2)
      @(negedge clk);
    end
    // strobe with a sampled-position pixel that must not count (R8)
    pix_valid = 1'b1; pix_x = 4'd2; pix_y = 4'd1; resid = 9'sd100;
    frame_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_end = 1'b0; pix_valid = 1'b0;
    if (swap) begin   // R7: late changes are ignored
      near_k = 8'd255; far_k = 8'd255; var_limit = '0; detail_en = ~det;
    end
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R3 class not yet updated", noise_class, prev_cls);
    @(posedge clk);
    @(negedge clk);
    chk(req, noise_class, exp_c);
    total++;
    if (noise_class == 2'b11) begin
      fails++;
      $display("FAIL R9 actual=%0d expected=not 3", noise_class);
    end
    prev_cls = exp_c;
  endtask

  task automatic set_two_level(input int a);
    for (int i = 0; i < NS; i++) smp[i] = (i % 2 == 0) ? a : -a;
  endtask
  task automatic set_spikes(input int n, input int v);
    for (int i = 0; i < NS; i++) smp[i] = (i < n) ? v : 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset class", noise_class, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 class after reset release", noise_class, 0);

    set_two_level(6);  run_frame("R4 R2 two-level gauss", 1'b1, 24, 64, 36, 1'b0);
    set_spikes(1, 40); run_frame("R4 single spike impulsive", 1'b1, 24, 64, 36, 1'b0);
    set_spikes(2, 40); run_frame("R4 two spikes contaminated", 1'b1, 24, 64, 36, 1'b0);
    set_spikes(2, 40); run_frame("R4 near limit just below ratio", 1'b1, 32, 64, 36, 1'b0);
    set_spikes(2, 40); run_frame("R4 near limit just above ratio", 1'b1, 33, 64, 36, 1'b0);
    set_spikes(2, 40); run_frame("R4 far limit low impulsive", 1'b1, 8, 32, 36, 1'b0);
    for (int i = 0; i < NS; i++) smp[i] = 7;
    run_frame("R5 constant detail zero thresholds", 1'b1, 0, 0, 0, 1'b0);
    run_frame("R5 constant basic zero limit", 1'b0, 0, 0, 0, 1'b0);
    set_two_level(6);  run_frame("R6 variance at limit gauss", 1'b0, 24, 64, 36, 1'b0);
    set_two_level(6);  run_frame("R6 variance over limit impulsive", 1'b0, 24, 64, 35, 1'b0);
    set_spikes(1, 4);  run_frame("R6 heavy tail small variance gauss", 1'b0, 24, 64, 36, 1'b0);
    set_spikes(2, 40); run_frame("R6 basic never contaminated", 1'b0, 24, 64, 200, 1'b0);
    set_spikes(1, 40); run_frame("R7 late threshold change ignored", 1'b1, 24, 64, 36, 1'b1);
    set_two_level(3);  run_frame("R8 fresh frame after swap", 1'b1, 24, 64, 36, 1'b0);
    for (int i = 0; i < NS; i++) smp[i] = (i * 5) % 17 - 8;
    run_frame("R4 R2 mixed pattern", 1'b1, 24, 64, 36, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule